// File: doc/BRIEF.md
# Crypto DMA Channel Controller

This block schedules block transfers between an external bus master and a crypto engine. It has two channels. The inbound channel (0) fetches words from external memory for the engine or for the key store. The outbound channel (1) writes result, tag or digest words from the engine back to external memory. Software loads each channel with a start address, a byte length and a start pulse. After that the engine paces the work one block at a time. Each request from the engine produces one burst on the bus of at most one block (four 32-bit words). The last block of a channel may be shorter.

No internal address is held. The engine-side target is fixed by the module-select input, so the controller only counts words to know when a channel has finished. On the engine side it returns an acknowledge pulse per channel. The bus side is a simple interface that moves one word per strobe: `m_req` stays high with `m_addr` and `m_write` until the bus returns `m_ack`, and each acknowledged cycle moves one word.

Top module: `crypto_dma_seq`

## Requirements
- R1: While reset is held and right after it is released, `m_req`, both busy flags, both done flags, both acknowledges and `eng_data_done` are 0.
- R2: When the key store is not selected (`ks_sel`=0), channel 0 starts a burst only after it has seen `eng_in_req` high in an idle cycle. Its bursts are reads (`m_write`=0).
- R3: Channel 1 starts a burst only after it has seen `eng_out_req` high in an idle cycle. Its bursts are writes (`m_write`=1).
- R4: A burst holds `m_req`=1 and moves `min(4, remaining words)` words. The first word uses the channel's current address, and the address rises by 4 for each acknowledged word. Without `m_ack`, the address is held. The channel's word count is `len[LEN_W-1:2]`.
- R5: A channel's acknowledge (`eng_in_ack` for channel 0, `eng_out_ack` for channel 1) pulses for one cycle in three cases: when its start pulse is accepted, in the cycle after the last word of each burst, and when its final word is moved. The last two cases give a single pulse.
- R6: Busy and done are never both high. When the final word is moved, busy clears and done sets. Done stays set until the next accepted start, which clears it.
- R7: `eng_data_done` pulses once, together with `eng_in_ack`, in the cycle after the last word of channel 0. Channel 1 never raises it.
- R8: With `ks_sel`=1, a start pulse on channel 1 is ignored: no busy flag and no acknowledge. Channel 0 then runs its bursts back to back without waiting for `eng_in_req`.
- R9: When both channels are pending in the same idle cycle, channel 1 gets the bus first.
- R10: A start with a length below 4 bytes sets done and pulses the acknowledge, with no bus traffic.
- R11: A start pulse on a busy channel is ignored. The channel keeps its address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ks_sel | input | 1 | 1 selects the key store as the internal target |
| ch0_go | input | 1 | Start pulse for the inbound channel |
| ch0_addr | input | ADDR_W | Inbound start address |
| ch0_len | input | LEN_W | Inbound length in bytes |
| ch1_go | input | 1 | Start pulse for the outbound channel |
| ch1_addr | input | ADDR_W | Outbound start address |
| ch1_len | input | LEN_W | Outbound length in bytes |
| eng_in_req | input | 1 | Engine can take the next block |
| eng_out_req | input | 1 | Engine has a block ready |
| eng_in_ack | output | 1 | Inbound acknowledge pulse |
| eng_out_ack | output | 1 | Outbound acknowledge pulse |
| eng_data_done | output | 1 | Pulse after the last inbound word |
| m_req | output | 1 | Bus word request |
| m_write | output | 1 | 1 = write to external memory |
| m_addr | output | ADDR_W | Bus byte address |
| m_ack | input | 1 | Word accepted this cycle |
| ch0_busy | output | 1 | Inbound channel active |
| ch0_done | output | 1 | Inbound channel finished (sticky) |
| ch1_busy | output | 1 | Outbound channel active |
| ch1_done | output | 1 | Outbound channel finished (sticky) |

## Verification
The checker watches several properties on every cycle:
- each burst is opened only by the request matching its direction;
- the address is held while a word stalls and rises by one word after each acknowledge;
- busy and done are never both high;
- `eng_data_done` only comes with the inbound acknowledge;
- the outbound channel wins a tie;
- the key store never sees an outbound burst.

Only the bench scenarios can show the rest:
- the burst lengths, including the short final block;
- the exact number of acknowledge pulses per operation;
- the behaviour of ignored starts, which is checked by reading addresses and flags at the ports;
- zero-length completion.

// File: rtl/crypto_dma_seq.sv
module crypto_dma_seq #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BLK_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ks_sel,
  input  logic              ch0_go,
  input  logic [ADDR_W-1:0] ch0_addr,
  input  logic [LEN_W-1:0]  ch0_len,
  input  logic              ch1_go,
  input  logic [ADDR_W-1:0] ch1_addr,
  input  logic [LEN_W-1:0]  ch1_len,
  input  logic              eng_in_req,
  input  logic              eng_out_req,
  output logic              eng_in_ack,
  output logic              eng_out_ack,
  output logic              eng_data_done,
  output logic              m_req,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  input  logic              m_ack,
  output logic              ch0_busy,
  output logic              ch0_done,
  output logic              ch1_busy,
  output logic              ch1_done
);
  localparam int WCW = LEN_W - 2;
  localparam int BCW = $clog2(BLK_WORDS + 1);
  localparam logic [WCW-1:0] BLK_W = WCW'(BLK_WORDS);

  logic [ADDR_W-1:0] addr_q [2];
  logic [WCW-1:0]    left_q [2];
  logic [ADDR_W-1:0] addr_in [2];
  logic [LEN_W-1:0]  len_in [2];
  logic [BCW-1:0]    bsz [2];
  logic [1:0]        busy_q, done_q, ack_q, go_v;
  logic              in_burst, act, dd_q;
  logic [BCW-1:0]    bleft;
  logic              pend0, pend1, fire;

  assign addr_in[0] = ch0_addr;
  assign addr_in[1] = ch1_addr;
  assign len_in[0]  = ch0_len;
  assign len_in[1]  = ch1_len;
  assign go_v       = {ch1_go & ~ks_sel, ch0_go};

  assign pend0 = busy_q[0] & (ks_sel | eng_in_req);
  assign pend1 = busy_q[1] & eng_out_req & ~ks_sel;
  assign fire  = in_burst & m_ack;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    logic hit, acc;
    logic [WCW-1:0] nwords;
    assign hit    = fire & (act == 1'(i));
    assign acc    = go_v[i] & ~busy_q[i];
    assign nwords = len_in[i][LEN_W-1:2];
    assign bsz[i] = (left_q[i] < BLK_W) ? BCW'(left_q[i]) : BCW'(BLK_WORDS);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[i] <= '0;
        left_q[i] <= '0;
        busy_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        ack_q[i]  <= 1'b0;
      end else begin
        ack_q[i] <= 1'b0;
        if (acc) begin
          addr_q[i] <= addr_in[i];
          left_q[i] <= nwords;
          busy_q[i] <= (nwords != '0);
          done_q[i] <= (nwords == '0);
          ack_q[i]  <= 1'b1;
        end else if (hit) begin
          addr_q[i] <= addr_q[i] + ADDR_W'(4);
          left_q[i] <= left_q[i] - 1'b1;
          if (left_q[i] == WCW'(1)) begin
            busy_q[i] <= 1'b0;
            done_q[i] <= 1'b1;
            ack_q[i]  <= 1'b1;
          end else if (bleft == BCW'(1)) begin
            ack_q[i]  <= 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_burst <= 1'b0;
      act      <= 1'b0;
      bleft    <= '0;
      dd_q     <= 1'b0;
    end else begin
      dd_q <= fire & ~act & (left_q[0] == WCW'(1));
      if (!in_burst) begin
        if (pend1) begin
          in_burst <= 1'b1;
          act      <= 1'b1;
          bleft    <= bsz[1];
        end else if (pend0) begin
          in_burst <= 1'b1;
          act      <= 1'b0;
          bleft    <= bsz[0];
        end
      end else if (fire) begin
        bleft <= bleft - 1'b1;
        if (bleft == BCW'(1)) in_burst <= 1'b0;
      end
    end
  end

  assign m_req         = in_burst;
  assign m_write       = act;
  assign m_addr        = addr_q[act];
  assign eng_in_ack    = ack_q[0];
  assign eng_out_ack   = ack_q[1];
  assign eng_data_done = dd_q;
  assign ch0_busy      = busy_q[0];
  assign ch0_done      = done_q[0];
  assign ch1_busy      = busy_q[1];
  assign ch1_done      = done_q[1];
endmodule

// File: rtl/crypto_dma_seq_chk.sv
module crypto_dma_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ks_sel,
  input logic              eng_in_req,
  input logic              eng_out_req,
  input logic              eng_in_ack,
  input logic              eng_data_done,
  input logic              m_req,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic              m_ack,
  input logic              ch0_busy,
  input logic              ch0_done,
  input logic              ch1_busy,
  input logic              ch1_done
);
  // R2
  in_burst_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) && !m_write && !$past(ks_sel) |-> $past(eng_in_req));
  // R3
  out_burst_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) && m_write |-> $past(eng_out_req));
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_write));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_ack |=> !m_req || (m_addr == $past(m_addr) + ADDR_W'(4)));
  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ch0_busy && ch0_done) && !(ch1_busy && ch1_done));
  // R7
  data_done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_data_done |-> eng_in_ack && ch0_done);
  // R8
  ks_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) && $past(ks_sel) |-> !m_write);
  // R9
  out_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) && !m_write |-> !$past(ch1_busy && eng_out_req && !ks_sel));
endmodule

bind crypto_dma_seq crypto_dma_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ks_sel(ks_sel), .eng_in_req(eng_in_req),
  .eng_out_req(eng_out_req), .eng_in_ack(eng_in_ack), .eng_data_done(eng_data_done),
  .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_ack(m_ack),
  .ch0_busy(ch0_busy), .ch0_done(ch0_done), .ch1_busy(ch1_busy), .ch1_done(ch1_done)
);

// File: tb/crypto_dma_seq_bench.sv
`timescale 1ns/100ps
module crypto_dma_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0, ks_sel = 1'b0;
  logic ch0_go = 1'b0, ch1_go = 1'b0;
  logic [31:0] ch0_addr = '0, ch1_addr = '0;
  logic [15:0] ch0_len = '0, ch1_len = '0;
  logic eng_in_req = 1'b0, eng_out_req = 1'b0, m_ack = 1'b0;
  logic eng_in_ack, eng_out_ack, eng_data_done, m_req, m_write;
  logic [31:0] m_addr;
  logic ch0_busy, ch0_done, ch1_busy, ch1_done;

  crypto_dma_seq u_crypto_dma_seq (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int nw, nb, in_ack_n, out_ack_n, dd_n;
  logic [31:0] log_addr [64];
  logic        log_wr [64];
  int          blen [16];
  logic stall_en = 1'b0, prev_req = 1'b0, cyc = 1'b0;

  always @(negedge clk) begin
    cyc   = ~cyc;
    m_ack = m_req && !(stall_en && cyc);
    if (m_req && !prev_req) nb++;
    if (m_req && m_ack) begin
      if (nw < 64) begin log_addr[nw] = m_addr; log_wr[nw] = m_write; end
      nw++;
      if (nb > 0 && nb <= 16) blen[nb-1]++;
    end
    prev_req = m_req;
    if (eng_in_ack) in_ack_n++;
    if (eng_out_ack) out_ack_n++;
    if (eng_data_done) dd_n++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    nw = 0; nb = 0; in_ack_n = 0; out_ack_n = 0; dd_n = 0;
    for (int i = 0; i < 16; i++) blen[i] = 0;
  endtask

  task automatic go(int ch, logic [31:0] a, logic [15:0] l);
    if (ch == 0) begin ch0_addr = a; ch0_len = l; ch0_go = 1'b1; end
    else begin ch1_addr = a; ch1_len = l; ch1_go = 1'b1; end
    tick();
    ch0_go = 1'b0; ch1_go = 1'b0;
  endtask

  task automatic wait_done(int ch);
    for (int i = 0; i < 300; i++) begin
      if ((ch == 0 && ch0_done) || (ch == 1 && ch1_done)) break;
      tick();
    end
    tick(2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick(3);
    chk(!m_req && !ch0_busy && !ch1_busy && !ch0_done && !ch1_done &&
        !eng_in_ack && !eng_out_ack && !eng_data_done, "R1 reset", m_req, 0);
    rst_n = 1'b1; tick();
    chk(!m_req && !ch0_busy && !ch1_busy, "R1 after release", m_req, 0);
  endtask

  task automatic t_inbound();
    clear_log(); ks_sel = 1'b0; stall_en = 1'b1; eng_in_req = 1'b0;
    go(0, 32'h0000_1000, 16'd40);
    tick(10);
    chk(nw == 0 && ch0_busy, "R2 no burst without request", nw, 0);
    eng_in_req = 1'b1;
    wait_done(0);
    eng_in_req = 1'b0; stall_en = 1'b0;
    chk(nw == 10, "R4 inbound word count", nw, 10);
    for (int i = 0; i < 10; i++)
      chk(log_addr[i] == 32'h1000 + 4*i && !log_wr[i], "R4 inbound address", log_addr[i], 32'h1000 + 4*i);
    chk(nb == 3 && blen[0] == 4 && blen[1] == 4 && blen[2] == 2, "R4 short last burst", blen[2], 2);
    chk(in_ack_n == 4, "R5 inbound ack pulses", in_ack_n, 4);
    chk(dd_n == 1, "R7 data done once", dd_n, 1);
    chk(ch0_done && !ch0_busy, "R6 done set busy clear", ch0_done, 1);
  endtask

  task automatic t_outbound();
    clear_log(); ks_sel = 1'b0; eng_out_req = 1'b0;
    go(1, 32'hFFFF_FFE0, 16'd24);
    tick(6);
    chk(nw == 0, "R3 no burst without request", nw, 0);
    eng_out_req = 1'b1;
    wait_done(1);
    eng_out_req = 1'b0;
    chk(nw == 6 && log_wr[0] && log_wr[5], "R3 outbound writes", nw, 6);
    chk(log_addr[5] == 32'hFFFF_FFF4, "R4 high address range", log_addr[5], 32'hFFFF_FFF4);
    chk(nb == 2 && blen[1] == 2, "R4 outbound bursts", blen[1], 2);
    chk(out_ack_n == 3, "R5 outbound ack pulses", out_ack_n, 3);
    chk(dd_n == 0, "R7 no data done outbound", dd_n, 0);
  endtask

  task automatic t_keystore();
    clear_log(); ks_sel = 1'b1; eng_in_req = 1'b0; eng_out_req = 1'b1;
    go(1, 32'h2000, 16'd16);
    tick(4);
    chk(!ch1_busy && out_ack_n == 0 && nw == 0, "R8 outbound start ignored", out_ack_n, 0);
    eng_out_req = 1'b0;
    go(0, 32'h3000, 16'd32);
    wait_done(0);
    chk(nw == 8 && nb == 2 && ch0_done, "R8 key store runs without request", nw, 8);
    chk(!log_wr[0] && log_addr[7] == 32'h301C, "R8 key store reads", log_addr[7], 32'h301C);
    ks_sel = 1'b0;
  endtask

  task automatic t_arbitrate();
    clear_log(); eng_in_req = 1'b1; eng_out_req = 1'b1;
    ch0_addr = 32'h4000; ch0_len = 16'd16; ch1_addr = 32'h5000; ch1_len = 16'd16;
    ch0_go = 1'b1; ch1_go = 1'b1; tick(); ch0_go = 1'b0; ch1_go = 1'b0;
    wait_done(0); wait_done(1);
    eng_in_req = 1'b0; eng_out_req = 1'b0;
    chk(log_wr[0] && log_addr[0] == 32'h5000, "R9 outbound first", log_addr[0], 32'h5000);
    chk(nw == 8 && !log_wr[4] && log_addr[4] == 32'h4000, "R9 inbound after", log_addr[4], 32'h4000);
  endtask

  task automatic t_zero_len();
    clear_log();
    go(1, 32'h6000, 16'd2);
    tick(3);
    chk(ch1_done && !ch1_busy && out_ack_n == 1 && nw == 0, "R10 empty channel", out_ack_n, 1);
  endtask

  task automatic t_busy_go();
    clear_log(); eng_in_req = 1'b0;
    go(0, 32'h7000, 16'd16);
    chk(ch0_busy && !ch0_done, "R6 done cleared by start", ch0_done, 0);
    tick(2);
    go(0, 32'h8000, 16'd64);
    tick(2);
    chk(in_ack_n == 1, "R11 second start not acked", in_ack_n, 1);
    eng_in_req = 1'b1;
    wait_done(0);
    eng_in_req = 1'b0;
    chk(nw == 4 && log_addr[0] == 32'h7000, "R11 first config kept", log_addr[0], 32'h7000);
  endtask

  initial begin
    clear_log();
    t_reset();
    t_inbound();
    t_outbound();
    t_keystore();
    t_arbitrate();
    t_zero_len();
    t_busy_go();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule